// File: doc/BRIEF.md
# UART Register and Interrupt Controller

This block is the software-visible side of a simple 8-bit, no-parity, one-stop-bit UART. It sits on an APB slave port and owns everything a driver sees. That is one holding byte per direction, the full and overrun flags for each byte, a control word, a latched interrupt status word and a 20-bit baud divisor. It produces five interrupt lines: transmit, receive, transmit overrun, receive overrun and a combined line.

Towards the line side it drives a transmit serializer through a start pulse with a byte and a done return. It accepts bytes from a receive deserializer as a byte with a one-cycle strobe. The bit-level shifters and the baud tick generator are outside the block. Only the divisor and its validity flag are exported to them.

When hardware sets a flag in the same cycle that software clears it with a write-one-to-clear access, the hardware set wins, so no event is lost.

Top module: `uart_regblk`

## Requirements
- R1: After reset, STATE (0x04), CTRL (0x08), INTSTATUS (0x0C), BAUDDIV (0x10) and the receive byte at DATA (0x00) all read 0. All five interrupt lines are low and `tx_start` is low.
- R2: Every transfer completes with no wait state (`pready`=1, `pslverr`=0). A read of an unmapped offset (for example 0x014 or 0x800) returns 0. Writes to unmapped or identification offsets change no register.
- R3: A write to CTRL keeps only bits 6:0 of the write data, and a read of CTRL returns them. Bit 0 is TX enable, bit 1 is RX enable, bit 2 is TX interrupt enable, bit 3 is RX interrupt enable, bit 4 is TX-overrun interrupt enable, bit 5 is RX-overrun interrupt enable and bit 6 is a test-mode bit.
- R4: A write to BAUDDIV keeps only bits 19:0 of the write data, and `baud_ok` is high exactly when the stored divisor is 16 or more.
- R5: A write to DATA while STATE bit 0 (TX full) is clear loads the transmit byte and sets TX full. `tx_start` then pulses high for one cycle with `tx_byte` equal to that byte, in the first cycle where TX enable and `baud_ok` are both high. The pulse is never raised while either one is low.
- R6: A write to DATA while a transmit is in flight reloads the byte, sets STATE bit 2 (TX overrun), keeps TX full and raises no new `tx_start`.
- R7: A `tx_done` pulse for the transfer in flight clears TX full. If CTRL bit 2 is set, that transition sets INTSTATUS bit 0.
- R8: A receive strobe while CTRL bit 1 is clear changes nothing: the receive byte, STATE and INTSTATUS stay as they were.
- R9: A receive strobe while RX is enabled stores the byte and sets STATE bit 1 (RX full). It also sets INTSTATUS bit 1 if CTRL bit 3 is set. A read of DATA returns the byte and clears RX full.
- R10: A receive strobe while RX full is set sets STATE bit 3 (RX overrun), overwrites the byte and leaves RX full set.
- R11: INTSTATUS bits 2 and 3 always equal STATE bits 2 and 3 ANDed with CTRL bits 4 and 5. Writing 1 to bit 2 or bit 3 of STATE, or of INTSTATUS, clears the matching overrun flag.
- R12: INTSTATUS bits 0 and 1 are cleared by writing 1 to them. A hardware set of any flag in the same cycle as a software clear of that flag leaves the flag set.
- R13: `irq_tx`, `irq_rx`, `irq_txo` and `irq_rxo` equal INTSTATUS bits 0 to 3, and `irq_any` is their OR.
- R14: The twelve word offsets 0xFD0 to 0xFFC read back byte i of the `ID_BYTES` parameter (bits 8i+7:8i) in bits 7:0, where i is (offset - 0xFD0)/4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when high |
| paddr | input | 12 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Transfer complete, always high |
| pslverr | output | 1 | Transfer error, always low |
| tx_byte | output | 8 | Byte offered to the serializer |
| tx_start | output | 1 | One-cycle start request to the serializer |
| tx_done | input | 1 | Serializer finished the current byte |
| rx_byte | input | 8 | Byte from the deserializer |
| rx_strobe | input | 1 | One-cycle receive strobe |
| baud_div | output | 20 | Stored baud divisor |
| baud_ok | output | 1 | Divisor is valid (16 or more) |
| irq_tx | output | 1 | Transmit interrupt |
| irq_rx | output | 1 | Receive interrupt |
| irq_txo | output | 1 | Transmit overrun interrupt |
| irq_rxo | output | 1 | Receive overrun interrupt |
| irq_any | output | 1 | OR of the four interrupts |

## Verification
The bound checker watches the handshake and flag rules on every cycle: `tx_start` is a single-cycle pulse, a write to a full transmit buffer raises TX overrun, completion empties the buffer, a disabled receiver leaves its byte untouched, a strobe into a full receive buffer raises RX overrun, a receive interrupt survives a same-cycle clear, and a DATA read empties the receive buffer. The bench scenarios are what show the register-level picture. These include the CTRL and BAUDDIV masks and the divisor threshold, swept over the whole small range. They also cover the identification bytes, the live AND behind the overrun interrupt bits, and the two separate clear paths for overrun. Finally they check the exact bytes read back after overwrite and the priority of an overrun arriving while software clears it.

// File: rtl/uart_regblk_pkg.sv
package uart_regblk_pkg;

  localparam int BYTE_W = 8;
  localparam int BUS_W  = 32;
  localparam int ADR_W  = 12;

  localparam logic [ADR_W-1:0] OFS_DATA  = 12'h000;
  localparam logic [ADR_W-1:0] OFS_STAT  = 12'h004;
  localparam logic [ADR_W-1:0] OFS_CTRL  = 12'h008;
  localparam logic [ADR_W-1:0] OFS_ISR   = 12'h00C;
  localparam logic [ADR_W-1:0] OFS_DIV   = 12'h010;
  localparam logic [ADR_W-1:0] OFS_ID_LO = 12'hFD0;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_DATA,
    SEL_STAT,
    SEL_CTRL,
    SEL_ISR,
    SEL_DIV,
    SEL_ID
  } reg_sel_e;

  // Map a byte address to the register it selects.
  function automatic reg_sel_e decode_ofs(input logic [ADR_W-1:0] a);
    if (a[1:0] != 2'b00) return SEL_NONE;
    if (a >= OFS_ID_LO) return SEL_ID;
    case (a)
      OFS_DATA: return SEL_DATA;
      OFS_STAT: return SEL_STAT;
      OFS_CTRL: return SEL_CTRL;
      OFS_ISR:  return SEL_ISR;
      OFS_DIV:  return SEL_DIV;
      default:  return SEL_NONE;
    endcase
  endfunction

  // A divisor is usable once it reaches the lower bound.
  function automatic logic divisor_usable(input logic [31:0] d, input logic [31:0] lo);
    return d >= lo;
  endfunction

  // Pick byte ((a - base) / 4) out of the identification table.
  function automatic logic [BYTE_W-1:0] id_byte(input logic [95:0] tbl,
                                                input logic [ADR_W-1:0] a);
    logic [95:0] s;
    s = tbl >> (8 * ((a - OFS_ID_LO) >> 2));
    return s[BYTE_W-1:0];
  endfunction

endpackage

// File: rtl/uart_apb_decode.sv
module uart_apb_decode
  import uart_regblk_pkg::*;
(
  input  logic             psel,
  input  logic             penable,
  input  logic             pwrite,
  input  logic [ADR_W-1:0] paddr,
  output reg_sel_e         sel,
  output logic             wr_data,
  output logic             wr_stat,
  output logic             wr_ctrl,
  output logic             wr_isr,
  output logic             wr_div,
  output logic             rd_data
);

  logic acc;

  assign sel = psel ? decode_ofs(paddr) : SEL_NONE;
  assign acc = psel & penable;

  assign wr_data = acc &  pwrite & (sel == SEL_DATA);
  assign wr_stat = acc &  pwrite & (sel == SEL_STAT);
  assign wr_ctrl = acc &  pwrite & (sel == SEL_CTRL);
  assign wr_isr  = acc &  pwrite & (sel == SEL_ISR);
  assign wr_div  = acc &  pwrite & (sel == SEL_DIV);
  assign rd_data = acc & ~pwrite & (sel == SEL_DATA);

endmodule

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [BW-1:0] load_byte,
  input  logic          go_ok,
  input  logic          ovr_clr,
  input  logic          tx_done,
  output logic [BW-1:0] tx_byte,
  output logic          tx_start,
  output logic          full,
  output logic          ovr,
  output logic          done_ok
);

  logic [BW-1:0] buf_q;
  logic          full_q, ovr_q, busy_q;
  logic          full_eff;

  // Completion is honoured only for a transfer actually in flight.
  assign done_ok  = tx_done & busy_q;
  // A completion in the same cycle frees the buffer for the new write.
  assign full_eff = full_q & ~done_ok;
  assign tx_start = full_q & go_ok & ~busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q  <= '0;
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      if (load) buf_q <= load_byte;

      if (load)         full_q <= 1'b1;
      else if (done_ok) full_q <= 1'b0;

      if (load && full_eff) ovr_q <= 1'b1;
      else if (ovr_clr)     ovr_q <= 1'b0;

      if (done_ok)       busy_q <= 1'b0;
      else if (tx_start) busy_q <= 1'b1;
    end
  end

  assign tx_byte = buf_q;
  assign full    = full_q;
  assign ovr     = ovr_q;

endmodule

// File: rtl/uart_rx_hold.sv
module uart_rx_hold #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_en,
  input  logic          rx_strobe,
  input  logic [BW-1:0] rx_byte,
  input  logic          pop,
  input  logic          ovr_clr,
  output logic [BW-1:0] rx_buf,
  output logic          full,
  output logic          ovr,
  output logic          take
);

  logic [BW-1:0] buf_q;
  logic          full_q, ovr_q;

  assign take = rx_strobe & rx_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q  <= '0;
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      if (take) buf_q <= rx_byte;

      if (take)     full_q <= 1'b1;
      else if (pop) full_q <= 1'b0;

      // A byte read out in this same cycle is not lost.
      if (take && full_q && !pop) ovr_q <= 1'b1;
      else if (ovr_clr)           ovr_q <= 1'b0;
    end
  end

  assign rx_buf = buf_q;
  assign full   = full_q;
  assign ovr    = ovr_q;

endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl #(
  parameter int NLAT = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NLAT-1:0] lat_set,
  input  logic [NLAT-1:0] lat_clr,
  input  logic            tx_ovr,
  input  logic            rx_ovr,
  input  logic            txo_ie,
  input  logic            rxo_ie,
  output logic [3:0]      isr,
  output logic            irq_tx,
  output logic            irq_rx,
  output logic            irq_txo,
  output logic            irq_rxo,
  output logic            irq_any
);

  logic [NLAT-1:0] lat_q;

  // Latched bits: a hardware set beats a same-cycle software clear.
  for (genvar g = 0; g < NLAT; g++) begin : g_lat
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          lat_q[g] <= 1'b0;
      else if (lat_set[g]) lat_q[g] <= 1'b1;
      else if (lat_clr[g]) lat_q[g] <= 1'b0;
    end
  end

  // Overrun bits are live, not stored.
  assign isr = {rx_ovr & rxo_ie, tx_ovr & txo_ie, lat_q[1], lat_q[0]};

  assign irq_tx  = isr[0];
  assign irq_rx  = isr[1];
  assign irq_txo = isr[2];
  assign irq_rxo = isr[3];
  assign irq_any = |isr;

endmodule

// File: rtl/uart_regblk.sv
module uart_regblk
  import uart_regblk_pkg::*;
#(
  parameter int          DIV_W    = 20,
  parameter int          MIN_DIV  = 16,
  parameter logic [95:0] ID_BYTES = 96'h5A_A5_3C_C3_00_2E_71_19_00_00_00_07
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADR_W-1:0]  paddr,
  input  logic [BUS_W-1:0]  pwdata,
  output logic [BUS_W-1:0]  prdata,
  output logic              pready,
  output logic              pslverr,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              tx_start,
  input  logic              tx_done,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              rx_strobe,
  output logic [DIV_W-1:0]  baud_div,
  output logic              baud_ok,
  output logic              irq_tx,
  output logic              irq_rx,
  output logic              irq_txo,
  output logic              irq_rxo,
  output logic              irq_any
);

  localparam int CTRL_W = 7;

  reg_sel_e          sel;
  logic              data_wr, stat_wr, ctrl_wr, isr_wr, div_wr, data_rd;
  logic [CTRL_W-1:0] ctrl_q;
  logic [DIV_W-1:0]  div_q;
  logic              tx_full_w, tx_ovr_w, tx_done_ok;
  logic              rx_full_w, rx_ovr_w, rx_take;
  logic [BYTE_W-1:0] rx_buf_w;
  logic [3:0]        isr_w;
  logic              txo_clr, rxo_clr;
  logic [1:0]        lat_set, lat_clr;
  wire               pwdata_unused = ^pwdata[BUS_W-1:DIV_W];

  uart_apb_decode u_dec (
    .psel    (psel),
    .penable (penable),
    .pwrite  (pwrite),
    .paddr   (paddr),
    .sel     (sel),
    .wr_data (data_wr),
    .wr_stat (stat_wr),
    .wr_ctrl (ctrl_wr),
    .wr_isr  (isr_wr),
    .wr_div  (div_wr),
    .rd_data (data_rd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      div_q  <= '0;
    end else begin
      if (ctrl_wr) ctrl_q <= pwdata[CTRL_W-1:0];
      if (div_wr)  div_q  <= pwdata[DIV_W-1:0];
    end
  end

  assign baud_div = div_q;
  assign baud_ok  = divisor_usable(32'(div_q), 32'(MIN_DIV));

  // Overrun flags clear from either STATE or INTSTATUS (bits 2 and 3).
  assign txo_clr = (stat_wr | isr_wr) & pwdata[2];
  assign rxo_clr = (stat_wr | isr_wr) & pwdata[3];

  uart_tx_hold #(.BW(BYTE_W)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (data_wr),
    .load_byte (pwdata[BYTE_W-1:0]),
    .go_ok     (ctrl_q[0] & baud_ok),
    .ovr_clr   (txo_clr),
    .tx_done   (tx_done),
    .tx_byte   (tx_byte),
    .tx_start  (tx_start),
    .full      (tx_full_w),
    .ovr       (tx_ovr_w),
    .done_ok   (tx_done_ok)
  );

  uart_rx_hold #(.BW(BYTE_W)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_en     (ctrl_q[1]),
    .rx_strobe (rx_strobe),
    .rx_byte   (rx_byte),
    .pop       (data_rd),
    .ovr_clr   (rxo_clr),
    .rx_buf    (rx_buf_w),
    .full      (rx_full_w),
    .ovr       (rx_ovr_w),
    .take      (rx_take)
  );

  assign lat_set = {rx_take & ctrl_q[3], tx_done_ok & ctrl_q[2]};
  assign lat_clr = {isr_wr & pwdata[1], isr_wr & pwdata[0]};

  uart_irq_ctrl #(.NLAT(2)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .lat_set (lat_set),
    .lat_clr (lat_clr),
    .tx_ovr  (tx_ovr_w),
    .rx_ovr  (rx_ovr_w),
    .txo_ie  (ctrl_q[4]),
    .rxo_ie  (ctrl_q[5]),
    .isr     (isr_w),
    .irq_tx  (irq_tx),
    .irq_rx  (irq_rx),
    .irq_txo (irq_txo),
    .irq_rxo (irq_rxo),
    .irq_any (irq_any)
  );

  always_comb begin
    prdata = '0;
    case (sel)
      SEL_DATA: prdata = BUS_W'(rx_buf_w);
      SEL_STAT: prdata = BUS_W'({rx_ovr_w, tx_ovr_w, rx_full_w, tx_full_w});
      SEL_CTRL: prdata = BUS_W'(ctrl_q);
      SEL_ISR:  prdata = BUS_W'(isr_w);
      SEL_DIV:  prdata = BUS_W'(div_q);
      SEL_ID:   prdata = BUS_W'(id_byte(ID_BYTES, paddr));
      default:  prdata = '0;
    endcase
  end

  assign pready  = 1'b1;
  assign pslverr = 1'b0;

endmodule

// File: rtl/uart_regblk_chk.sv
module uart_regblk_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_start,
  input logic       tx_full_w,
  input logic       tx_ovr_w,
  input logic       tx_done_ok,
  input logic       data_wr,
  input logic       data_rd,
  input logic       rx_take,
  input logic       rx_strobe,
  input logic       rx_full_w,
  input logic       rx_ovr_w,
  input logic [7:0] rx_buf_w,
  input logic [6:0] ctrl_q,
  input logic       irq_rx
);

  a_r5_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |=> !tx_start);

  a_r6_write_full_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr && tx_full_w && !tx_done_ok |=> tx_ovr_w);

  a_r7_done_empties: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done_ok && !data_wr |=> !tx_full_w);

  a_r8_rx_disabled_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    rx_strobe && !ctrl_q[1] |=> $stable(rx_buf_w));

  a_r9_pop_empties: assert property (@(posedge clk) disable iff (!rst_n)
    data_rd && !rx_take |=> !rx_full_w);

  a_r10_rx_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    rx_take && rx_full_w && !data_rd |=> rx_ovr_w);

  a_r12_rx_irq_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    rx_take && ctrl_q[3] |=> irq_rx);

endmodule

bind uart_regblk uart_regblk_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .tx_start   (tx_start),
  .tx_full_w  (tx_full_w),
  .tx_ovr_w   (tx_ovr_w),
  .tx_done_ok (tx_done_ok),
  .data_wr    (data_wr),
  .data_rd    (data_rd),
  .rx_take    (rx_take),
  .rx_strobe  (rx_strobe),
  .rx_full_w  (rx_full_w),
  .rx_ovr_w   (rx_ovr_w),
  .rx_buf_w   (rx_buf_w),
  .ctrl_q     (ctrl_q),
  .irq_rx     (irq_rx)
);

// File: tb/uart_regblk_tb_top.sv
module uart_regblk_tb_top;

  localparam logic [95:0] EXP_ID = 96'h5A_A5_3C_C3_00_2E_71_19_00_00_00_07;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready, pslverr;
  logic [7:0]  tx_byte;
  logic        tx_start;
  logic        tx_done = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        rx_strobe = 1'b0;
  logic [19:0] baud_div;
  logic        baud_ok;
  logic        irq_tx, irq_rx, irq_txo, irq_rxo, irq_any;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  uart_regblk dut_i (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pslverr(pslverr), .tx_byte(tx_byte), .tx_start(tx_start), .tx_done(tx_done),
    .rx_byte(rx_byte), .rx_strobe(rx_strobe), .baud_div(baud_div),
    .baud_ok(baud_ok), .irq_tx(irq_tx), .irq_rx(irq_rx), .irq_txo(irq_txo),
    .irq_rxo(irq_rxo), .irq_any(irq_any)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apb_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  // Write with a receive strobe landing on the same clock edge.
  task automatic apb_wr_rx(input logic [11:0] a, input logic [31:0] d, input logic [7:0] b);
    @(negedge clk); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge clk); penable = 1; rx_byte = b; rx_strobe = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0; rx_strobe = 0;
  endtask

  task automatic apb_rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(negedge clk); penable = 1;
    #1 d = prdata;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] v;
    apb_rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic rx_push(input logic [7:0] b);
    @(negedge clk); rx_byte = b; rx_strobe = 1;
    @(negedge clk); rx_strobe = 0;
  endtask

  task automatic tx_finish();
    @(negedge clk); tx_done = 1;
    @(negedge clk); tx_done = 0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] v;
    repeat (5) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    chk("R1 irq_any", 32'(irq_any), 0);
    chk("R1 tx_start", 32'(tx_start), 0);
    rd_chk("R1 STATE", 12'h004, 0);
    rd_chk("R1 CTRL", 12'h008, 0);
    rd_chk("R1 INTSTATUS", 12'h00C, 0);
    rd_chk("R1 BAUDDIV", 12'h010, 0);
    rd_chk("R1 DATA", 12'h000, 0);

    // R2 bus behaviour and ignored writes
    @(negedge clk); psel = 1; paddr = 12'h008; penable = 1;
    #1 chk("R2 pready", 32'(pready), 1);
    chk("R2 pslverr", 32'(pslverr), 0);
    @(negedge clk); psel = 0; penable = 0;
    rd_chk("R2 unmapped 0x014", 12'h014, 0);
    rd_chk("R2 unmapped 0x800", 12'h800, 0);
    apb_wr(12'h014, 32'hFFFF_FFFF);
    apb_wr(12'h800, 32'hFFFF_FFFF);
    apb_wr(12'hFD0, 32'hFFFF_FFFF);
    rd_chk("R2 CTRL untouched", 12'h008, 0);
    rd_chk("R2 BAUDDIV untouched", 12'h010, 0);
    rd_chk("R2 STATE untouched", 12'h004, 0);
    rd_chk("R2 ID untouched", 12'hFD0, EXP_ID[7:0]);

    // R14 identification bytes
    for (int i = 0; i < 12; i++) begin
      logic [95:0] s;
      s = EXP_ID >> (8 * i);
      rd_chk("R14 ID byte", 12'(12'hFD0 + 4 * i), {24'd0, s[7:0]});
    end

    // R3 CTRL mask sweep
    for (int i = 0; i < 128; i++) begin
      apb_wr(12'h008, {25'h1F0_0A5, 7'(i)} ^ 32'hFFFF_FF80);
      rd_chk("R3 CTRL mask", 12'h008, 32'(i));
    end
    apb_wr(12'h008, 0);

    // R4 divisor mask and threshold sweep
    for (int d = 0; d < 24; d++) begin
      apb_wr(12'h010, 32'hABC0_0000 | 32'(d));
      rd_chk("R4 BAUDDIV", 12'h010, 32'(d));
      chk("R4 baud_ok", 32'(baud_ok), (d >= 16) ? 1 : 0);
    end
    apb_wr(12'h010, 32'hFFFF_FFFF);
    rd_chk("R4 BAUDDIV max", 12'h010, 32'h000F_FFFF);
    chk("R4 baud_ok max", 32'(baud_ok), 1);

    // R5 start gated by invalid divisor, then released
    apb_wr(12'h010, 8);
    apb_wr(12'h008, 32'h01);
    apb_wr(12'h000, 32'h5A);
    chk("R5 no start bad div", 32'(tx_start), 0);
    rd_chk("R5 STATE full", 12'h004, 32'h1);
    chk("R5 still no start", 32'(tx_start), 0);
    apb_wr(12'h010, 16);
    chk("R5 start after div", 32'(tx_start), 1);
    chk("R5 tx_byte", 32'(tx_byte), 32'h5A);
    @(negedge clk);
    chk("R5 start one cycle", 32'(tx_start), 0);

    // R6 write while in flight
    apb_wr(12'h000, 32'h44);
    rd_chk("R6 STATE full+ovr", 12'h004, 32'h5);
    chk("R6 byte reloaded", 32'(tx_byte), 32'h44);
    chk("R6 no new start", 32'(tx_start), 0);

    // R7 completion with TX interrupt disabled
    tx_finish();
    rd_chk("R7 STATE after done", 12'h004, 32'h4);
    rd_chk("R7 ISR no tx irq", 12'h00C, 0);
    chk("R7 no restart", 32'(tx_start), 0);

    // R11 live TX overrun interrupt, cleared through STATE
    apb_wr(12'h008, 32'h15);
    rd_chk("R11 ISR txo live", 12'h00C, 32'h4);
    chk("R13 irq_txo", 32'(irq_txo), 1);
    chk("R13 irq_any", 32'(irq_any), 1);
    apb_wr(12'h004, 32'h4);
    rd_chk("R11 ISR after STATE clr", 12'h00C, 0);
    rd_chk("R11 STATE after clr", 12'h004, 0);

    // R5 TX disabled holds the byte; R7 interrupt on completion
    apb_wr(12'h008, 32'h04);
    apb_wr(12'h000, 32'h33);
    chk("R5 no start tx off", 32'(tx_start), 0);
    apb_wr(12'h008, 32'h05);
    chk("R5 start on enable", 32'(tx_start), 1);
    chk("R5 tx_byte 33", 32'(tx_byte), 32'h33);
    tx_finish();
    rd_chk("R7 STATE empty", 12'h004, 0);
    rd_chk("R7 ISR tx", 12'h00C, 32'h1);
    chk("R13 irq_tx", 32'(irq_tx), 1);
    apb_wr(12'h00C, 32'h1);
    rd_chk("R12 ISR tx cleared", 12'h00C, 0);
    chk("R13 irq_any low", 32'(irq_any), 0);

    // R11 TX overrun cleared through INTSTATUS
    apb_wr(12'h000, 32'h10);
    apb_wr(12'h000, 32'h11);
    apb_wr(12'h008, 32'h15);
    chk("R11 irq_txo set", 32'(irq_txo), 1);
    apb_wr(12'h00C, 32'h4);
    rd_chk("R11 STATE txo via ISR", 12'h004, 32'h1);
    tx_finish();
    rd_chk("R7 ISR after second done", 12'h00C, 32'h1);
    apb_wr(12'h00C, 32'h1);

    // R8 receiver disabled
    apb_wr(12'h008, 0);
    rx_push(8'h77);
    rd_chk("R8 STATE unchanged", 12'h004, 0);
    rd_chk("R8 ISR unchanged", 12'h00C, 0);
    rd_chk("R8 DATA unchanged", 12'h000, 0);

    // R9 receive sweep
    apb_wr(12'h008, 32'h0A);
    for (int i = 0; i < 8; i++) begin
      logic [7:0] b;
      b = 8'(8'hA5 ^ (i * 37));
      rx_push(b);
      rd_chk("R9 STATE rx full", 12'h004, 32'h2);
      chk("R13 irq_rx", 32'(irq_rx), 1);
      rd_chk("R9 DATA byte", 12'h000, {24'd0, b});
      rd_chk("R9 STATE emptied", 12'h004, 0);
      apb_wr(12'h00C, 32'h2);
      chk("R12 irq_rx cleared", 32'(irq_rx), 0);
    end

    // R10 receive overrun
    rx_push(8'h11);
    rx_push(8'h22);
    rd_chk("R10 STATE full+ovr", 12'h004, 32'hA);
    rd_chk("R11 ISR rxo masked", 12'h00C, 32'h2);
    apb_wr(12'h008, 32'h2A);
    rd_chk("R11 ISR rxo live", 12'h00C, 32'hA);
    chk("R13 irq_rxo", 32'(irq_rxo), 1);
    rd_chk("R10 DATA overwritten", 12'h000, 32'h22);
    rd_chk("R10 STATE after read", 12'h004, 32'h8);
    apb_wr(12'h00C, 32'h8);
    rd_chk("R11 STATE rxo via ISR", 12'h004, 0);
    rd_chk("R11 ISR after rxo clr", 12'h00C, 32'h2);

    // R12 hardware set beats a same-cycle clear
    rx_push(8'h55);
    rx_push(8'h66);
    apb_wr_rx(12'h004, 32'h8, 8'h67);
    rd_chk("R12 rxo set wins", 12'h004, 32'hA);
    rd_chk("R12 DATA latest", 12'h000, 32'h67);
    apb_wr_rx(12'h00C, 32'h2, 8'h68);
    rd_chk("R12 rx irq set wins", 12'h00C, 32'hA);
    apb_wr(12'h004, 32'h8);
    rd_chk("R11 STATE rxo cleared", 12'h004, 32'h2);

    summary();
  end

endmodule